// File: doc/BRIEF.md
# Dual Down-Counting Reload Timer

This block holds two independent 32-bit down-counters behind a plain register write/read port. Each counter steps down by one on its own tick. The tick comes either from a power-of-two divider of the bus clock or from an external fixed-reference strobe. A counter that reaches zero either loads its reload value on its next tick (periodic mode) or stays parked at zero (one-shot mode).

Each expiry latches a flag in a shared event status register. Each flag drives one level interrupt line until software clears it. To clear a flag, software writes a word that holds a zero at that flag's position. All per-timer settings live in one shared control word. Software starts a timer by writing its reload and current values, then setting its enable bit together with the chosen reload mode, tick source and divider code.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every register reads zero, both interrupt lines are low and neither counter moves.
- R2: The control word is at offset 0x00. Timer 0 uses bit 0 as enable, bit 1 as auto-reload, bit 11 as fixed-reference select and bits 21:19 as divider code. Timer 1 uses bit 2 as enable, bit 3 as auto-reload, bit 12 as fixed-reference select and bits 24:22 as divider code. Every other bit reads zero, so writing all ones reads back 0x01F8180F.
- R3: With the divided source selected, code n gives one tick every 2^n bus-clock cycles. The first tick comes 2^n cycles after the enable write. Each tick lowers a nonzero counter by one.
- R4: With fixed-reference select set, a counter steps once per cycle in which the reference strobe is high, and the divider code has no effect.
- R5: With auto-reload set, a counter at zero loads its reload value on its next tick. A reload value of N-1 therefore gives a period of N ticks, and a reload of 0xFFFFFFFF gives a free-running wrap.
- R6: With auto-reload clear, a counter that reaches zero stays at zero and raises its flag only once.
- R7: A timer's flag is set in the cycle its counter steps from 1 to 0. The event status register at offset 0x04 shows timer 0's flag at bit 0 and timer 1's at bit 8, with all other bits zero. Each interrupt line follows its flag as a level.
- R8: Writing the status register clears each flag whose bit position holds a zero in the written word. Flags whose bit holds a one are unchanged.
- R9: Clearing a timer's enable bit freezes its counter. It also restarts that timer's divider, so the next enable waits a full 2^n cycles for its first tick.
- R10: A software write to a current-value register takes effect even when a tick lands in the same cycle.
- R11: Reload registers sit at 0x10 (timer 0) and 0x18 (timer 1). Current-value registers sit at 0x14 and 0x1C. All four read back what was written. Read data is registered and appears one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| ref_tick | input | 1 | Fixed-reference strobe, one cycle high per reference tick |
| irq | output | 2 | Level interrupt per timer, bit t for timer t |

## Verification
The assertions assume that a write strobe lasts a single cycle and targets only the listed offsets. They also assume the reference strobe is a clean one-cycle pulse that is synchronous to the bus clock. The bench drives each write for exactly one cycle between falling edges and always lowers the strobe afterwards. It separates reference pulses by at least one idle cycle, so every pulse counts as a distinct tick. It stops a counter by writing the control word, never by removing the clock, so all observed values are frozen ones taken through the normal read path.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR  = 2;
  localparam int DATA_W   = 32;
  localparam int CODE_W   = 3;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;

  function automatic logic [7:0] ofs_reload(input int t);
    return 8'(8'h10 + 8 * t);
  endfunction

  function automatic logic [7:0] ofs_value(input int t);
    return 8'(8'h14 + 8 * t);
  endfunction

  function automatic int pos_en(input int t);
    return 2 * t;
  endfunction

  function automatic int pos_rel(input int t);
    return 2 * t + 1;
  endfunction

  function automatic int pos_ref(input int t);
    return 11 + t;
  endfunction

  function automatic int pos_code(input int t);
    return 19 + CODE_W * t;
  endfunction

  function automatic int pos_flag(input int t);
    return 8 * t;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      m[pos_en(t)]  = 1'b1;
      m[pos_rel(t)] = 1'b1;
      m[pos_ref(t)] = 1'b1;
      for (int b = 0; b < CODE_W; b++) m[pos_code(t) + b] = 1'b1;
    end
    return m;
  endfunction

  typedef struct packed {
    logic              en;
    logic              rel;
    logic              use_ref;
    logic [CODE_W-1:0] code;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              use_ref,
  input  logic              ref_tick,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PW = (1 << CODE_W) - 1;

  logic [PW-1:0] div_q;
  logic [PW-1:0] mask;

  always_comb begin
    for (int i = 0; i < PW; i++) mask[i] = (i < int'(code));
  end

  always_comb begin
    if (!en)          tick = 1'b0;
    else if (use_ref) tick = ref_tick;
    else              tick = ((div_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || use_ref) div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && !use_ref && code != '0) |=> !(tick && !use_ref && $stable(code))); // R3
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         rel_en,
  input  logic [W-1:0] reload_val,
  input  logic         val_wr,
  input  logic [W-1:0] val_wdata,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (val_wr)     cnt_q <= val_wdata;
    else if (tick) begin
      if (cnt_q == '0) begin
        if (rel_en)      cnt_q <= reload_val;
      end else           cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count  = cnt_q;
  assign expire = tick && !val_wr && (cnt_q == W'(1));

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    val_wr |=> (cnt_q == $past(val_wdata))); // R10
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick && !val_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_RELOAD_TAKE: assert property (@(posedge clk) disable iff (rst)
    (tick && !val_wr && cnt_q == '0 && rel_en) |=> (cnt_q == $past(reload_val))); // R5
  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !rel_en && !val_wr) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] keep,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q;
  logic [N-1:0] clr;

  assign clr = clr_wr ? ~keep : '0;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= set | (flag_q & ~clr);
  end

  assign flags = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flag_q[i]); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr[i]) |=> flag_q[i]); // R8
    AST_FLAG_WZC: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && !keep[i] && !set[i]) |=> !flag_q[i]); // R8
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import tmr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick,
  output logic [NUM_TMR-1:0] irq
);
  localparam logic [DATA_W-1:0] CMASK = ctrl_mask();

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] reload_q [NUM_TMR];
  logic [DATA_W-1:0] count    [NUM_TMR];
  logic [NUM_TMR-1:0] expire;
  logic [NUM_TMR-1:0] val_wr;
  logic [NUM_TMR-1:0] keep;
  logic [NUM_TMR-1:0] flags;
  tmr_cfg_t           cfg [NUM_TMR];
  logic               stat_wr;

  always_ff @(posedge clk) begin
    if (rst)                                   ctrl_q <= '0;
    else if (bus_wr && bus_addr == AW'(OFS_CTRL)) ctrl_q <= bus_wdata & CMASK;
  end

  assign stat_wr = bus_wr && (bus_addr == AW'(OFS_STAT));

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam int PE = pos_en(t);
    localparam int PR = pos_rel(t);
    localparam int PF = pos_ref(t);
    localparam int PC = pos_code(t);
    localparam int PS = pos_flag(t);

    assign cfg[t].en      = ctrl_q[PE];
    assign cfg[t].rel     = ctrl_q[PR];
    assign cfg[t].use_ref = ctrl_q[PF];
    assign cfg[t].code    = ctrl_q[PC +: CODE_W];
    assign val_wr[t]      = bus_wr && (bus_addr == AW'(ofs_value(t)));
    assign keep[t]        = bus_wdata[PS];

    always_ff @(posedge clk) begin
      if (rst) reload_q[t] <= '0;
      else if (bus_wr && bus_addr == AW'(ofs_reload(t))) reload_q[t] <= bus_wdata;
    end

    logic tick;

    tmr_prescaler #(.CODE_W(CODE_W)) presc_i (
      .clk      (clk),
      .rst      (rst),
      .en       (cfg[t].en),
      .use_ref  (cfg[t].use_ref),
      .ref_tick (ref_tick),
      .code     (cfg[t].code),
      .tick     (tick)
    );

    tmr_counter #(.W(DATA_W)) cnt_i (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .rel_en     (cfg[t].rel),
      .reload_val (reload_q[t]),
      .val_wr     (val_wr[t]),
      .val_wdata  (bus_wdata),
      .count      (count[t]),
      .expire     (expire[t])
    );

    AST_FREEZE_OFF: assert property (@(posedge clk) disable iff (rst)
      (!cfg[t].en && !val_wr[t]) |=> $stable(count[t])); // R9
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[t]) |-> $past(expire[t])); // R7
  end

  tmr_status #(.N(NUM_TMR)) stat_i (
    .clk    (clk),
    .rst    (rst),
    .set    (expire),
    .clr_wr (stat_wr),
    .keep   (keep),
    .flags  (flags)
  );

  assign irq = flags;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      bus_rdata <= '0;
      if (bus_addr == AW'(OFS_CTRL)) bus_rdata <= ctrl_q;
      if (bus_addr == AW'(OFS_STAT)) begin
        for (int t = 0; t < NUM_TMR; t++) bus_rdata[pos_flag(t)] <= flags[t];
      end
      for (int t = 0; t < NUM_TMR; t++) begin
        if (bus_addr == AW'(ofs_reload(t))) bus_rdata <= reload_q[t];
        if (bus_addr == AW'(ofs_value(t)))  bus_rdata <= count[t];
      end
    end
  end

  AST_IRQ_RESET: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0)); // R1
endmodule

// File: tb/dual_reload_timer_tb.sv
`timescale 1ns/1ps
module dual_reload_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_tick = 1'b0;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_reload_timer dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick), .irq(irq)
  );

  typedef struct packed {
    logic        tsel;
    logic [31:0] v;
    logic [31:0] r;
    logic        rel;
    logic [2:0]  code;
    logic [15:0] w;
    logic [31:0] exp_v;
    logic        exp_f;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd10, 32'd0,          1'b0, 3'd0, 16'd4,   32'd6,          1'b0}, // R3
    '{1'b0, 32'd3,  32'd0,          1'b0, 3'd0, 16'd8,   32'd0,          1'b1}, // R6
    '{1'b0, 32'd2,  32'd4,          1'b1, 3'd0, 16'd6,   32'd1,          1'b1}, // R5
    '{1'b1, 32'd20, 32'd0,          1'b0, 3'd2, 16'd13,  32'd17,         1'b0}, // R3
    '{1'b0, 32'd0,  32'hFFFF_FFFF,  1'b1, 3'd0, 16'd3,   32'hFFFF_FFFD,  1'b0}, // R5
    '{1'b1, 32'd5,  32'd0,          1'b0, 3'd5, 16'd100, 32'd2,          1'b0}, // R3
    '{1'b0, 32'd1,  32'd0,          1'b0, 3'd1, 16'd2,   32'd0,          1'b1}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input int t, input logic rel, input logic rsel,
                                      input logic [2:0] code);
    logic [31:0] c;
    c = '0;
    c[2*t] = 1'b1;
    c[2*t+1] = rel;
    c[11+t] = rsel;
    c[19+3*t +: 3] = code;
    return c;
  endfunction

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 / R11: reset state
    check("R1 irq", {30'd0, irq}, 32'd0);
    foreach (VECS[k]) begin end
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h04, d); check("R1 stat", d, 0);
    rd(8'h10, d); check("R1 rld0", d, 0);
    rd(8'h14, d); check("R1 val0", d, 0);
    rd(8'h18, d); check("R1 rld1", d, 0);
    rd(8'h1C, d); check("R1 val1", d, 0);

    // R11 readback
    wr(8'h10, 32'hA5A5_1234); rd(8'h10, d); check("R11 rld0", d, 32'hA5A5_1234);
    wr(8'h1C, 32'h0000_BEEF); rd(8'h1C, d); check("R11 val1", d, 32'h0000_BEEF);

    // R2 control mask (reference selected on both, no strobe, nothing moves)
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 ctrl mask", d, 32'h01F8_180F);
    wr(8'h00, 32'h0);
    rd(8'h1C, d); check("R4 no strobe no step", d, 32'h0000_BEEF);

    // table walk
    for (int k = 0; k < NV; k++) begin
      int t;
      t = int'(VECS[k].tsel);
      wr(8'h00, 0);
      wr(8'h04, 0);
      wr(8'h10 + 8'(8*t), VECS[k].r);
      wr(8'h14 + 8'(8*t), VECS[k].v);
      wr(8'h00, ctl(t, VECS[k].rel, 1'b0, VECS[k].code));
      repeat (int'(VECS[k].w) - 1) @(posedge clk);
      wr(8'h00, 0);
      rd(8'h14 + 8'(8*t), d);
      check($sformatf("R3/R5/R6 vec%0d value", k), d, VECS[k].exp_v);
      rd(8'h04, d);
      check($sformatf("R7 vec%0d stat", k), d, 32'(VECS[k].exp_f) << (8*t));
      check($sformatf("R7 vec%0d irq", k), 32'(irq[t]), 32'(VECS[k].exp_f));
    end

    // R10: write on a tick cycle wins
    wr(8'h14, 32'd100);
    wr(8'h00, ctl(0, 1'b0, 1'b0, 3'd0));
    wr(8'h14, 32'd50);
    wr(8'h00, 0);
    rd(8'h14, d); check("R10 write priority", d, 32'd49);

    // R9: frozen while off
    repeat (20) @(posedge clk);
    rd(8'h14, d); check("R9 freeze", d, 32'd49);

    // R9: divider restarts on re-enable
    wr(8'h14, 32'd40);
    wr(8'h00, ctl(0, 1'b0, 1'b0, 3'd2));
    repeat (2) @(posedge clk);
    wr(8'h00, 0);
    wr(8'h00, ctl(0, 1'b0, 1'b0, 3'd2));
    @(posedge clk);
    wr(8'h00, 0);
    rd(8'h14, d); check("R9 divider restart", d, 32'd40);

    // R4: fixed reference, divider code ignored
    wr(8'h14, 32'd10);
    wr(8'h00, ctl(0, 1'b0, 1'b1, 3'd5));
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(posedge clk); #1 ref_tick = 1'b0;
      repeat (2) @(posedge clk);
    end
    wr(8'h00, 0);
    rd(8'h14, d); check("R4 reference steps", d, 32'd7);

    // R8: write-zero-to-clear
    wr(8'h04, 0);
    wr(8'h14, 32'd1);
    wr(8'h1C, 32'd1);
    wr(8'h00, ctl(0, 1'b0, 1'b0, 3'd0) | ctl(1, 1'b0, 1'b0, 3'd0));
    wr(8'h00, 0);
    rd(8'h04, d); check("R7 both flags", d, 32'h0000_0101);
    check("R7 both irq", {30'd0, irq}, 32'd3);
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, d); check("R8 clear bit0", d, 32'h0000_0100);
    check("R8 irq after clear0", {30'd0, irq}, 32'd2);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R8 ones no effect", d, 32'h0000_0100);
    wr(8'h04, 32'hFFFF_FEFF);
    rd(8'h04, d); check("R8 clear bit8", d, 32'h0);
    check("R8 irq low", {30'd0, irq}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule